// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block sits beside the receive and transmit paths of a 16550-style serial port. It gathers every interrupt cause: line errors, received data, the receive-FIFO character timeout, an empty transmit holding register and modem-line changes. Each cause is masked by its own enable bit, and the block ranks the live causes by a fixed priority. It presents the winning cause as a read-only identification byte and drives a single interrupt line.

Each cause clears in its own way. Error and modem-change causes are sticky until the matching status register is read. Received data follows a level supplied by the receive path. The timeout drops when the FIFO is accessed. The transmit-empty cause is cleared by a write to the transmit buffer, or by a read of the identification byte while that byte reports transmit-empty.

The bus decoder supplies read and write strobes. The receive path supplies the FIFO occupancy, push strobes and a tick once per character time.

Top module: `uart_int_ident`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `idByte` is 0x01 and `irq` is 0.
- R2: A pulse on any bit of `lineErr` makes the line-error cause pending. When it is enabled by `intEn[2]`, it outranks every other cause and reports low nibble 0110. It stays pending until `lsrRead`.
- R3: While `rxReady` is high and `intEn[0]` is set, the receive-data cause reports 0100. It follows the level and is not latched.
- R4: In FIFO mode with `intEn[0]` set, the timeout cause reports 1100 once `TO_CHARS` `charTick` pulses have arrived since the last push, the last buffer read, or the FIFO becoming non-empty. The tick count saturates. The cause drops after `rbrRead`, after `rxPush`, or when `rxCount` is 0. Receive data (0100) outranks the timeout.
- R5: With `fifoEn` low, the timeout cause never reports and bit 3 of `idByte` reads 0.
- R6: The transmit-empty cause becomes pending on a rising edge of `txEmpty`, or on a rising edge of `intEn[1]` while `txEmpty` is high. It reports 0010, below receive data, and clears on `thrWrite`.
- R7: An `idRead` clears the transmit-empty cause only when the `idByte` held during that read shows 0010. A read that shows any other code leaves the cause pending.
- R8: A pulse on any bit of `modemDelta` makes the modem cause pending. It has the lowest priority, reports 0000, and clears on `msrRead`.
- R9: Bits 7 and 6 of `idByte` both equal `fifoEn`, and bits 5 and 4 are always 0. With no enabled cause, the low nibble is 0001.
- R10: `irq` is the combinational OR of all enabled pending causes. A disabled cause neither drives `irq` nor appears in `idByte`.
- R11: `idByte` is a register. It shows the causes and `fifoEn` as they stood in the previous cycle, and it holds steady for the whole cycle in which it is read.
- R12: If a sticky cause (line error, modem, transmit-empty) receives a set event and a clear event in the same cycle, it stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineErr | input | 4 | Error event pulses: overrun, parity, framing, break |
| rxReady | input | 1 | Data ready, or FIFO level at or above the trigger |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| rxPush | input | 1 | A character entered the receive FIFO |
| rbrRead | input | 1 | Receive buffer read strobe |
| charTick | input | 1 | One pulse per character time |
| txEmpty | input | 1 | Transmit holding register empty (level) |
| thrWrite | input | 1 | Transmit buffer write strobe |
| modemDelta | input | 4 | Modem change pulses: CTS, DSR, RI trailing edge, DCD |
| intEn | input | 4 | Enables: [0] receive/timeout, [1] transmit-empty, [2] line error, [3] modem |
| fifoEn | input | 1 | FIFO mode enable |
| idRead | input | 1 | Identification byte read strobe |
| lsrRead | input | 1 | Line status read strobe |
| msrRead | input | 1 | Modem status read strobe |
| idByte | output | 8 | Registered identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `TO_CHARS` = 3 and `CNT_W` = 4. A timeout therefore needs only three ticks, and bench phases can reach saturation, the restart paths and the suppressed case many times each. The narrow occupancy field makes the empty-FIFO restart occur often during the randomized phase. That phase also makes set and clear strobes collide, and it produces identification reads while the reported code changes.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;

  // Masked, live interrupt causes handed from control to the datapath.
  typedef struct packed {
    logic lineAct;
    logic rxAct;
    logic toAct;
    logic txAct;
    logic modemAct;
    logic fifoMode;
  } srcVecT;

  localparam logic [3:0] ID_NONE  = 4'b0001;
  localparam logic [3:0] ID_LINE  = 4'b0110;
  localparam logic [3:0] ID_RX    = 4'b0100;
  localparam logic [3:0] ID_TO    = 4'b1100;
  localparam logic [3:0] ID_TX    = 4'b0010;
  localparam logic [3:0] ID_MODEM = 4'b0000;

endpackage

// File: rtl/uart_int_sticky.sv
module uart_int_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] setVec,
  input  logic         clr,
  output logic         pend
);

  logic anySet;
  assign anySet = |setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pend <= 1'b0;
    else if (anySet) pend <= 1'b1;
    else if (clr)    pend <= 1'b0;
  end

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    anySet |=> pend);

endmodule

// File: rtl/uart_int_ctrl.sv
module uart_int_ctrl
  import uart_int_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       lineErr,
  input  logic             rxReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             rxPush,
  input  logic             rbrRead,
  input  logic             charTick,
  input  logic             txEmpty,
  input  logic             thrWrite,
  input  logic [3:0]       modemDelta,
  input  logic [3:0]       intEn,
  input  logic             fifoEn,
  input  logic             idRead,
  input  logic             lsrRead,
  input  logic             msrRead,
  input  logic             txReported,
  output srcVecT           srcVec,
  output logic             irq
);

  localparam int TO_W = $clog2(TO_CHARS + 1);
  localparam logic [TO_W-1:0] TO_LIM = TO_W'(TO_CHARS);

  logic linePend, modemPend, txPend;
  logic txEmptyQ, txEnQ;
  logic txSet, txClr;
  logic [TO_W-1:0] toCnt;
  logic toRestart;

  uart_int_sticky #(.W(4)) lineFlag_i (
    .clk(clk), .rstN(rstN), .setVec(lineErr), .clr(lsrRead), .pend(linePend)
  );

  uart_int_sticky #(.W(4)) modemFlag_i (
    .clk(clk), .rstN(rstN), .setVec(modemDelta), .clr(msrRead), .pend(modemPend)
  );

  // Transmit-empty: edge of the level, or enable rising while empty.
  assign txSet = txEmpty & (~txEmptyQ | (intEn[1] & ~txEnQ));
  assign txClr = thrWrite | (idRead & txReported);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPend   <= 1'b0;
      txEmptyQ <= 1'b0;
      txEnQ    <= 1'b0;
    end else begin
      txEmptyQ <= txEmpty;
      txEnQ    <= intEn[1];
      if (txSet)      txPend <= 1'b1;
      else if (txClr) txPend <= 1'b0;
    end
  end

  // Character timeout counter.
  assign toRestart = rbrRead | rxPush | (rxCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           toCnt <= '0;
    else if (toRestart)                  toCnt <= '0;
    else if (charTick && toCnt < TO_LIM) toCnt <= toCnt + 1'b1;
  end

  always_comb begin
    srcVec.lineAct  = linePend & intEn[2];
    srcVec.rxAct    = rxReady & intEn[0];
    srcVec.toAct    = fifoEn & intEn[0] & (toCnt == TO_LIM);
    srcVec.txAct    = txPend & intEn[1];
    srcVec.modemAct = modemPend & intEn[3];
    srcVec.fifoMode = fifoEn;
  end

  assign irq = srcVec.lineAct | srcVec.rxAct | srcVec.toAct |
               srcVec.txAct | srcVec.modemAct;

  // R2
  line_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && lineErr == 4'b0) |=> !linePend);

  // R8
  modem_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msrRead && modemDelta == 4'b0) |=> !modemPend);

  // R6
  tx_write_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrite && !txSet) |=> !txPend);

  // R7
  tx_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idRead && txReported && !txSet) |=> !txPend);

  // R4
  to_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    toCnt <= TO_LIM);

  // R4
  to_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    toRestart |=> toCnt == '0);

endmodule

// File: rtl/uart_int_dp.sv
module uart_int_dp
  import uart_int_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  srcVecT     srcVec,
  output logic [7:0] idByte,
  output logic       txReported
);

  logic [3:0] code;

  always_comb begin
    if (srcVec.lineAct)       code = ID_LINE;
    else if (srcVec.rxAct)    code = ID_RX;
    else if (srcVec.toAct)    code = ID_TO;
    else if (srcVec.txAct)    code = ID_TX;
    else if (srcVec.modemAct) code = ID_MODEM;
    else                      code = ID_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idByte <= {4'b0000, ID_NONE};
    else       idByte <= {{2{srcVec.fifoMode}}, 2'b00, code};
  end

  assign txReported = (idByte[3:0] == ID_TX);

  // R2
  line_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcVec.lineAct |=> idByte[3:0] == ID_LINE);

  // R5
  to_suppress_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srcVec.fifoMode |=> !idByte[3]);

  // R9
  hi_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcVec.fifoMode |=> idByte[7:6] == 2'b11);

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_int_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       lineErr,
  input  logic             rxReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             rxPush,
  input  logic             rbrRead,
  input  logic             charTick,
  input  logic             txEmpty,
  input  logic             thrWrite,
  input  logic [3:0]       modemDelta,
  input  logic [3:0]       intEn,
  input  logic             fifoEn,
  input  logic             idRead,
  input  logic             lsrRead,
  input  logic             msrRead,
  output logic [7:0]       idByte,
  output logic             irq
);

  srcVecT srcVec;
  logic   txReported;

  uart_int_ctrl #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) ctrl_i (
    .clk(clk), .rstN(rstN), .lineErr(lineErr), .rxReady(rxReady),
    .rxCount(rxCount), .rxPush(rxPush), .rbrRead(rbrRead),
    .charTick(charTick), .txEmpty(txEmpty), .thrWrite(thrWrite),
    .modemDelta(modemDelta), .intEn(intEn), .fifoEn(fifoEn),
    .idRead(idRead), .lsrRead(lsrRead), .msrRead(msrRead),
    .txReported(txReported), .srcVec(srcVec), .irq(irq)
  );

  uart_int_dp dp_i (
    .clk(clk), .rstN(rstN), .srcVec(srcVec),
    .idByte(idByte), .txReported(txReported)
  );

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irq |=> idByte[0]);

endmodule

// File: tb/uart_int_ident_tb.sv
`timescale 1ns/1ps
module uart_int_ident_tb_top;

  localparam int CNT_W = 4;
  localparam int TO_CHARS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] lineErr = '0, modemDelta = '0, intEn = '0;
  logic [CNT_W-1:0] rxCount = '0;
  logic rxReady = 0, rxPush = 0, rbrRead = 0, charTick = 0, txEmpty = 0;
  logic thrWrite = 0, fifoEn = 0, idRead = 0, lsrRead = 0, msrRead = 0;
  logic [7:0] idByte;
  logic irq;

  always #2 clk = ~clk;

  uart_int_ident #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) dut_i (
    .clk(clk), .rstN(rstN), .lineErr(lineErr), .rxReady(rxReady),
    .rxCount(rxCount), .rxPush(rxPush), .rbrRead(rbrRead),
    .charTick(charTick), .txEmpty(txEmpty), .thrWrite(thrWrite),
    .modemDelta(modemDelta), .intEn(intEn), .fifoEn(fifoEn),
    .idRead(idRead), .lsrRead(lsrRead), .msrRead(msrRead),
    .idByte(idByte), .irq(irq)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  string phase = "R1";

  // Behavioural reference state
  bit mLine, mModem, mTx, mTxEQ, mEnQ;
  int mCnt;
  logic [7:0] mId;
  bit started = 0;

  function automatic string codeTag(logic [3:0] c);
    case (c)
      4'b0110: return "R2";
      4'b0100: return "R3";
      4'b1100: return "R4";
      4'b0010: return "R6";
      4'b0000: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) t=%0t idByte got %h expected %h", tag, phase, $time, got, exp);
    end
  endtask

  task automatic check1(string tag, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) t=%0t irq got %b expected %b", tag, phase, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      mLine = 0; mModem = 0; mTx = 0; mTxEQ = 0; mEnQ = 0; mCnt = 0;
      mId = 8'h01;
      // R1: reset values
      check8("R1", idByte, 8'h01);
      check1("R1", irq, 1'b0);
    end else begin
      bit aLine, aRx, aTo, aTx, aMod, txSetM, restart;
      logic [3:0] nc;
      aLine = mLine && intEn[2];
      aRx   = rxReady && intEn[0];
      aTo   = fifoEn && intEn[0] && (mCnt == TO_CHARS);
      aTx   = mTx && intEn[1];
      aMod  = mModem && intEn[3];
      // R10: combinational OR of enabled causes
      check1("R10", irq, aLine | aRx | aTo | aTx | aMod);
      // R11: registered snapshot of the previous cycle
      check8(codeTag(mId[3:0]), idByte, mId);
      if (aLine) nc = 4'b0110;
      else if (aRx) nc = 4'b0100;
      else if (aTo) nc = 4'b1100;
      else if (aTx) nc = 4'b0010;
      else if (aMod) nc = 4'b0000;
      else nc = 4'b0001;
      // R12: set beats clear
      if (lineErr != 0) mLine = 1; else if (lsrRead) mLine = 0;
      if (modemDelta != 0) mModem = 1; else if (msrRead) mModem = 0;
      txSetM = txEmpty && (!mTxEQ || (intEn[1] && !mEnQ));
      // R7: read clear only when the held byte showed 0010
      if (txSetM) mTx = 1;
      else if (thrWrite || (idRead && mId[3:0] == 4'b0010)) mTx = 0;
      mTxEQ = txEmpty; mEnQ = intEn[1];
      restart = rbrRead || rxPush || (rxCount == 0);
      if (restart) mCnt = 0;
      else if (charTick && mCnt < TO_CHARS) mCnt++;
      mId = {{2{fifoEn}}, 2'b00, nc};
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    cyc(3);
    rstN = 1; cyc(2);

    phase = "R6";  // edge of txEmpty
    intEn = 4'hF;
    txEmpty = 1; cyc(3);
    phase = "R7";  // read while showing 0010 clears
    pulse(idRead); cyc(2);
    txEmpty = 0; cyc(1); txEmpty = 1; cyc(1);
    lineErr = 4'b0001; cyc(1); lineErr = 0; cyc(2);
    pulse(idRead); cyc(2);          // showed 0110: THRE stays
    phase = "R2";
    pulse(lsrRead); cyc(3);         // THRE now visible
    phase = "R6";
    pulse(thrWrite); cyc(2);
    for (int b = 0; b < 4; b++) begin
      phase = "R2";
      lineErr = 4'(1 << b); cyc(1); lineErr = 0; cyc(2);
      pulse(lsrRead); cyc(1);
    end

    phase = "R8";
    for (int b = 0; b < 4; b++) begin
      modemDelta = 4'(1 << b); cyc(1); modemDelta = 0; cyc(2);
      pulse(msrRead); cyc(1);
    end

    phase = "R12";
    lineErr = 4'b1000; lsrRead = 1; cyc(1); lineErr = 0; lsrRead = 0; cyc(2);
    modemDelta = 4'b0010; msrRead = 1; cyc(1); modemDelta = 0; msrRead = 0; cyc(2);
    pulse(lsrRead); pulse(msrRead); cyc(1);

    phase = "R3";
    rxReady = 1; cyc(3);
    phase = "R10";
    intEn = 4'b1110; cyc(2);
    lineErr = 4'b0100; intEn = 4'b1010; cyc(1); lineErr = 0; cyc(2);
    intEn = 4'hF; cyc(2);
    pulse(lsrRead); rxReady = 0; cyc(2);

    phase = "R6";  // enable rising while empty
    intEn = 4'b1101; cyc(2); intEn = 4'hF; cyc(3);
    pulse(thrWrite); cyc(1);

    phase = "R9";
    fifoEn = 1; cyc(2);
    phase = "R4";
    rxCount = 2;
    for (int i = 0; i < 5; i++) begin pulse(charTick); cyc(1); end
    cyc(2);
    pulse(rbrRead); cyc(2);
    for (int i = 0; i < 4; i++) pulse(charTick);
    cyc(1); pulse(rxPush); cyc(1);
    for (int i = 0; i < 4; i++) pulse(charTick);
    rxReady = 1; cyc(2); rxReady = 0; cyc(1);
    rxCount = 0; cyc(2); rxCount = 3;
    for (int i = 0; i < 2; i++) pulse(charTick);
    cyc(2);
    phase = "R5";
    for (int i = 0; i < 4; i++) pulse(charTick);
    fifoEn = 0; cyc(3);
    fifoEn = 1; cyc(2); fifoEn = 0; rxCount = 0; cyc(2);

    phase = "R11";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      lineErr    = (r[3:0] == 0) ? 4'($urandom) : 4'b0;
      modemDelta = (r[7:4] == 0) ? 4'($urandom) : 4'b0;
      rxReady    = r[8] & r[9];
      rxPush     = r[14:10] == 0;
      rbrRead    = r[19:15] == 0;
      charTick   = r[20];
      txEmpty    = (r[24:21] == 0) ? ~txEmpty : txEmpty;
      thrWrite   = r[28:25] == 0;
      idRead     = r[29] & r[30];
      lsrRead    = r[31] & r[0];
      msrRead    = r[5] & r[6] & r[7];
      if (r[15:11] == 1) intEn = 4'($urandom);
      if (r[23:18] == 2) fifoEn = ~fifoEn;
      if (r[31:27] == 3) rxCount = CNT_W'($urandom);
      cyc(1);
    end
    lineErr = 0; modemDelta = 0; rxPush = 0; rbrRead = 0; charTick = 0;
    thrWrite = 0; idRead = 0; lsrRead = 0; msrRead = 0;
    cyc(3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule